// File: doc/BRIEF.md
# PAL raster timing generator

This block derives the complete horizontal and vertical timing of an interlaced PAL-style raster from a 16 MHz tick enable. Each line is a run of tick positions, and each field is a run of lines. The tick and line positions and the field phase are exposed so that a pixel or fetch engine downstream can lock onto them. The block drives a horizontal sync, a composite sync that also carries the field sync, a pixel-window enable and a marker for the start of the picture.

Line 0 of every field is the line in which field sync begins. In the even phase, field sync starts at the beginning of line 0, and the field holds `FIELD_LINES` lines. In the odd phase, field sync starts halfway through line 0, and the field holds one extra line. The distance between successive field syncs is therefore always `FIELD_LINES + 0.5` lines. The picture start line and the number of active lines are inputs. A typical setting is a start line of 38 with 256 active lines. The first complete usable line falls 23 lines after field sync begins.

An external sync strobe snaps the generator back to tick 0, line 0 of the even phase. This lets the raster be slaved to an incoming video source.

Top module: `pal_raster_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is tick 0, line 0, even field (`field_odd` = 0).
- R2: At each edge with `tick_en` high and `ext_sync` low, the tick position advances by one. From `LINE_TICKS-1` it wraps to 0 and advances the line. With `tick_en` low, tick, line and field all hold.
- R3: The even field (`field_odd`=0) holds lines 0 to `FIELD_LINES-1`, and the odd field holds lines 0 to `FIELD_LINES`. Wrapping past the last line returns to line 0 and flips the field phase.
- R4: `hs_n` is 0 exactly for tick positions 0 to `HS_TICKS-1` of every line.
- R5: The half-line index is 2*line plus 1 when the tick is at or beyond `LINE_TICKS/2`. Field sync covers half-lines 0 to 4 in the even field and half-lines 1 to 5 in the odd field. During those half-lines, `csync_n` is 1 for the first `HS_TICKS` ticks of each half-line and 0 for the rest.
- R6: Outside the field-sync half-lines, `csync_n` equals `hs_n`.
- R7: `pix_en` is 1 only when both of these hold:
  - the tick lies in [`PIX_START`, `PIX_START+PIX_TICKS`);
  - the line lies in [`pic_line`, `pic_line+act_lines`).

  This applies in both fields.
- R8: `pic_start` is 1 exactly while the tick is 0 and the line equals `pic_line`. It therefore occurs once per field when ticks run freely.
- R9: `ext_sync` high at an edge forces tick 0, line 0, even field on that edge, whatever `tick_en` is.
- R10: With `act_lines` = 0, `pix_en` stays 0 for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One raster tick (62.5 ns at the default rate) |
| ext_sync | input | 1 | Genlock strobe: restart at tick 0, line 0, even field |
| pic_line | input | LINE_W | Line (from field-sync start) where the picture begins |
| act_lines | input | LINE_W | Number of picture lines |
| hs_n | output | 1 | Horizontal sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| pix_en | output | 1 | Pixel window enable |
| pic_start | output | 1 | Start-of-picture marker |
| tick_cnt | output | TICK_W | Tick position in the line |
| line_cnt | output | LINE_W | Line position in the field |
| field_odd | output | 1 | Field phase, 1 in the odd (half-line shifted) field |

## Verification
The bench walks a full two-field frame for several picture windows. It targets the odd field's extra line: a design that gives both fields the same length would drift the field-sync phase and miscount picture lines in the odd field. Field sync is probed at its half-line edges. A wrong half-line offset would start or end the serrated composite sync one half-line off in one phase. The bench also exercises an empty picture window, the genlock strobe with ticks stalled, and a reset in mid-frame. A design that let the tick enable outrank the strobe, or that kept the field phase across it, would resume at the wrong position.

// File: rtl/pal_raster_pkg.sv
// Package: default raster geometry and the field phase type.
// Assumes: nothing; shared by every raster module.
package pal_raster_pkg;
    localparam int DEF_LINE_TICKS  = 1024;  // 64 us line at 16 MHz
    localparam int DEF_HS_TICKS    = 75;    // about 4.7 us of line sync
    localparam int DEF_PIX_START   = 264;   // multiple of 8, fetch aligned
    localparam int DEF_PIX_TICKS   = 640;   // 40 us of pixels
    localparam int DEF_FIELD_LINES = 312;   // even field; odd has one more
    localparam int VS_HALF_LINES   = 5;     // 2.5 lines of field sync

    typedef enum logic {
        FIELD_EVEN = 1'b0,
        FIELD_ODD  = 1'b1
    } field_e;
endpackage

// File: rtl/raster_hcount.sv
// Horizontal counter: tick position within a line, line-end strobe,
// line sync and half-line split.
// Assumes: LINE_TICKS is a power of two and HS_TICKS < LINE_TICKS/2.
module raster_hcount #(
    parameter  int LINE_TICKS = pal_raster_pkg::DEF_LINE_TICKS,
    parameter  int HS_TICKS   = pal_raster_pkg::DEF_HS_TICKS,
    localparam int TICK_W     = $clog2(LINE_TICKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ext_sync,
    output logic [TICK_W-1:0] tick_cnt,
    output logic              line_end,
    output logic              hs_n,
    output logic              upper_half,
    output logic [TICK_W-2:0] half_pos
);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(LINE_TICKS - 1);
    localparam logic [TICK_W-1:0] HS_END    = TICK_W'(HS_TICKS);
    localparam logic [TICK_W-1:0] TICK_ONE  = TICK_W'(1);

    // Tick position: cleared by reset or genlock, stepped on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (ext_sync)
            tick_cnt <= '0;
        else if (tick_en)
            tick_cnt <= line_end ? '0 : tick_cnt + TICK_ONE;
    end

    // Line end: last tick of the line is being consumed this cycle.
    assign line_end   = tick_en && (tick_cnt == LAST_TICK);
    // Line sync: low from the start of the line for HS_TICKS ticks.
    assign hs_n       = (tick_cnt >= HS_END);
    // Half-line split: top bit selects the second half of the line.
    assign upper_half = tick_cnt[TICK_W-1];
    assign half_pos   = tick_cnt[TICK_W-2:0];
endmodule

// File: rtl/raster_vcount.sv
// Vertical counter: line position within a field and field phase.
// Assumes: line_end comes from the horizontal counter of the same raster.
module raster_vcount #(
    parameter  int FIELD_LINES = pal_raster_pkg::DEF_FIELD_LINES,
    localparam int LINE_W      = $clog2(FIELD_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_sync,
    input  logic              line_end,
    output logic [LINE_W-1:0] line_cnt,
    output logic              field_odd
);
    import pal_raster_pkg::*;

    localparam logic [LINE_W-1:0] LAST_EVEN = LINE_W'(FIELD_LINES - 1);
    localparam logic [LINE_W-1:0] LAST_ODD  = LINE_W'(FIELD_LINES);
    localparam logic [LINE_W-1:0] LINE_ONE  = LINE_W'(1);

    field_e            field_q;
    logic [LINE_W-1:0] last_line;
    logic              field_end;

    // Last line: the odd field carries one extra line.
    assign last_line = (field_q == FIELD_ODD) ? LAST_ODD : LAST_EVEN;
    assign field_end = line_end && (line_cnt == last_line);

    // Line position and phase: cleared by reset or genlock, stepped per line.
    always_ff @(posedge clk) begin
        if (!rst_n || ext_sync) begin
            line_cnt <= '0;
            field_q  <= FIELD_EVEN;
        end else if (field_end) begin
            line_cnt <= '0;
            field_q  <= (field_q == FIELD_EVEN) ? FIELD_ODD : FIELD_EVEN;
        end else if (line_end) begin
            line_cnt <= line_cnt + LINE_ONE;
        end
    end

    assign field_odd = (field_q == FIELD_ODD);
endmodule

// File: rtl/raster_sync_decode.sv
// Sync and window decode: composite sync with half-line field sync,
// pixel window and picture start marker.
// Assumes: counters from raster_hcount/raster_vcount; pure combinational.
module raster_sync_decode #(
    parameter  int LINE_TICKS  = pal_raster_pkg::DEF_LINE_TICKS,
    parameter  int HS_TICKS    = pal_raster_pkg::DEF_HS_TICKS,
    parameter  int PIX_START   = pal_raster_pkg::DEF_PIX_START,
    parameter  int PIX_TICKS   = pal_raster_pkg::DEF_PIX_TICKS,
    parameter  int FIELD_LINES = pal_raster_pkg::DEF_FIELD_LINES,
    localparam int TICK_W      = $clog2(LINE_TICKS),
    localparam int LINE_W      = $clog2(FIELD_LINES + 1)
) (
    input  logic              hs_n_in,
    input  logic              upper_half,
    input  logic [TICK_W-2:0] half_pos,
    input  logic [TICK_W-1:0] tick_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] pic_line,
    input  logic [LINE_W-1:0] act_lines,
    output logic              csync_n,
    output logic              pix_en,
    output logic              pic_start
);
    import pal_raster_pkg::*;

    localparam logic [TICK_W-2:0] HS_HALF = (TICK_W-1)'(HS_TICKS);
    localparam logic [TICK_W:0]   PIX_LO  = (TICK_W+1)'(PIX_START);
    localparam logic [TICK_W:0]   PIX_HI  = (TICK_W+1)'(PIX_START + PIX_TICKS);

    logic [LINE_W:0] half_idx;
    logic [1:0]      vs_win;
    logic            vs_active;
    logic            h_win;
    logic            v_win;
    logic [LINE_W:0] v_end;

    // Half-line index: two per line, second half flagged by the top tick bit.
    assign half_idx = {line_cnt, upper_half};

    // Field sync window per phase; phase 0 starts at half-line 0.
    for (genvar ph = 0; ph < 2; ph++) begin : g_phase
        localparam logic [LINE_W:0] WIN_LO = (LINE_W+1)'(ph);
        localparam logic [LINE_W:0] WIN_HI = (LINE_W+1)'(ph + VS_HALF_LINES);
        if (ph == 0) begin : g_from_zero
            assign vs_win[ph] = (half_idx < WIN_HI);
        end else begin : g_shifted
            assign vs_win[ph] = (half_idx >= WIN_LO) && (half_idx < WIN_HI);
        end
    end

    assign vs_active = vs_win[field_odd];

    // Composite sync: inverted pulses per half-line in field sync, else line sync.
    always_comb begin
        if (vs_active)
            csync_n = (half_pos < HS_HALF);
        else
            csync_n = hs_n_in;
    end

    // Pixel window: fixed horizontal span gated by the programmed line range.
    assign h_win  = ({1'b0, tick_cnt} >= PIX_LO) && ({1'b0, tick_cnt} < PIX_HI);
    assign v_end  = {1'b0, pic_line} + {1'b0, act_lines};
    assign v_win  = (line_cnt >= pic_line) && ({1'b0, line_cnt} < v_end);
    assign pix_en = h_win && v_win;

    // Picture marker: first tick of the programmed start line.
    assign pic_start = (tick_cnt == '0) && (line_cnt == pic_line);
endmodule

// File: rtl/pal_raster_gen.sv
// Top: interlaced PAL-style raster timing generator with genlock strobe.
// Assumes: tick_en pulses at the raster tick rate; pic_line/act_lines static
// during a frame.
module pal_raster_gen #(
    parameter  int LINE_TICKS  = pal_raster_pkg::DEF_LINE_TICKS,
    parameter  int HS_TICKS    = pal_raster_pkg::DEF_HS_TICKS,
    parameter  int PIX_START   = pal_raster_pkg::DEF_PIX_START,
    parameter  int PIX_TICKS   = pal_raster_pkg::DEF_PIX_TICKS,
    parameter  int FIELD_LINES = pal_raster_pkg::DEF_FIELD_LINES,
    localparam int TICK_W      = $clog2(LINE_TICKS),
    localparam int LINE_W      = $clog2(FIELD_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ext_sync,
    input  logic [LINE_W-1:0] pic_line,
    input  logic [LINE_W-1:0] act_lines,
    output logic              hs_n,
    output logic              csync_n,
    output logic              pix_en,
    output logic              pic_start,
    output logic [TICK_W-1:0] tick_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              field_odd
);
    logic              line_end;
    logic              upper_half;
    logic [TICK_W-2:0] half_pos;

    raster_hcount #(
        .LINE_TICKS(LINE_TICKS),
        .HS_TICKS  (HS_TICKS)
    ) u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .ext_sync  (ext_sync),
        .tick_cnt  (tick_cnt),
        .line_end  (line_end),
        .hs_n      (hs_n),
        .upper_half(upper_half),
        .half_pos  (half_pos)
    );

    raster_vcount #(
        .FIELD_LINES(FIELD_LINES)
    ) u_vcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_sync (ext_sync),
        .line_end (line_end),
        .line_cnt (line_cnt),
        .field_odd(field_odd)
    );

    raster_sync_decode #(
        .LINE_TICKS (LINE_TICKS),
        .HS_TICKS   (HS_TICKS),
        .PIX_START  (PIX_START),
        .PIX_TICKS  (PIX_TICKS),
        .FIELD_LINES(FIELD_LINES)
    ) u_decode (
        .hs_n_in   (hs_n),
        .upper_half(upper_half),
        .half_pos  (half_pos),
        .tick_cnt  (tick_cnt),
        .line_cnt  (line_cnt),
        .field_odd (field_odd),
        .pic_line  (pic_line),
        .act_lines (act_lines),
        .csync_n   (csync_n),
        .pix_en    (pix_en),
        .pic_start (pic_start)
    );
endmodule

// File: rtl/pal_raster_gen_chk.sv
// Checker: temporal properties of the raster counters and decoded outputs.
// Assumes: bound to pal_raster_gen with matching parameters.
module pal_raster_gen_chk #(
    parameter  int LINE_TICKS  = pal_raster_pkg::DEF_LINE_TICKS,
    parameter  int FIELD_LINES = pal_raster_pkg::DEF_FIELD_LINES,
    localparam int TICK_W      = $clog2(LINE_TICKS),
    localparam int LINE_W      = $clog2(FIELD_LINES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              ext_sync,
    input logic [TICK_W-1:0] tick_cnt,
    input logic [LINE_W-1:0] line_cnt,
    input logic              field_odd,
    input logic              hs_n,
    input logic              pix_en,
    input logic              pic_start
);
    localparam logic [TICK_W-1:0] C_LAST_TICK = TICK_W'(LINE_TICKS - 1);
    localparam logic [TICK_W-1:0] C_TICK_ONE  = TICK_W'(1);
    localparam logic [LINE_W-1:0] C_LAST_EVEN = LINE_W'(FIELD_LINES - 1);
    localparam logic [LINE_W-1:0] C_LAST_ODD  = LINE_W'(FIELD_LINES);

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n) (tick_en && !ext_sync && tick_cnt != C_LAST_TICK) |=> (tick_cnt == $past(tick_cnt) + C_TICK_ONE));  // R2
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick_en && !ext_sync) |=> ($stable(tick_cnt) && $stable(line_cnt) && $stable(field_odd)));  // R2
    AST_EVEN_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (tick_en && !ext_sync && tick_cnt == C_LAST_TICK && line_cnt == C_LAST_EVEN && !field_odd) |=> (line_cnt == '0 && field_odd));  // R3
    AST_ODD_EXTRA: assert property (@(posedge clk) disable iff (!rst_n) (tick_en && !ext_sync && tick_cnt == C_LAST_TICK && line_cnt == C_LAST_EVEN && field_odd) |=> (line_cnt == C_LAST_ODD && field_odd));  // R3
    AST_GENLOCK: assert property (@(posedge clk) disable iff (!rst_n) ext_sync |=> (tick_cnt == '0 && line_cnt == '0 && !field_odd));  // R9
    AST_PIX_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n) pix_en |-> hs_n);  // R7
    AST_PIC_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n) pic_start |-> (tick_cnt == '0 && !pix_en));  // R8
endmodule

bind pal_raster_gen pal_raster_gen_chk #(
    .LINE_TICKS (LINE_TICKS),
    .FIELD_LINES(FIELD_LINES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .ext_sync (ext_sync),
    .tick_cnt (tick_cnt),
    .line_cnt (line_cnt),
    .field_odd(field_odd),
    .hs_n     (hs_n),
    .pix_en   (pix_en),
    .pic_start(pic_start)
);

// File: tb/pal_raster_gen_bench.sv
// Bench: frame walks over a table of picture windows with a per-cycle
// reference model, then directed reset, hold, genlock and field-length tests.
module pal_raster_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LT  = 32;
    localparam int HS  = 3;
    localparam int PS  = 8;
    localparam int PT  = 16;
    localparam int FL  = 12;
    localparam int TW  = $clog2(LT);
    localparam int LW  = $clog2(FL + 1);
    localparam int FRAME_TICKS = (2 * FL + 1) * LT;
    localparam int NVEC = 4;

    // Vectors: picture start line, active lines, expected pixel ticks per frame.
    localparam int VEC_PIC [NVEC] = '{2, 0, 5, 3};
    localparam int VEC_ACT [NVEC] = '{4, 3, 0, 10};
    localparam int VEC_PIX [NVEC] = '{128, 96, 0, 304};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          ext_sync = 1'b0;
    logic [LW-1:0] pic_line = '0;
    logic [LW-1:0] act_lines = '0;
    logic          hs_n, csync_n, pix_en, pic_start, field_odd;
    logic [TW-1:0] tick_cnt;
    logic [LW-1:0] line_cnt;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    int m_tick = 0;
    int m_line = 0;
    int m_field = 0;

    pal_raster_gen #(
        .LINE_TICKS(LT), .HS_TICKS(HS), .PIX_START(PS),
        .PIX_TICKS(PT), .FIELD_LINES(FL)
    ) u_pal_raster_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_sync(ext_sync),
        .pic_line(pic_line), .act_lines(act_lines),
        .hs_n(hs_n), .csync_n(csync_n), .pix_en(pix_en), .pic_start(pic_start),
        .tick_cnt(tick_cnt), .line_cnt(line_cnt), .field_odd(field_odd)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model state.
    task automatic compare_all();
        int hl, hpos, pic, act;
        bit invs, hs_e, cs_e, pix_e, pic_e;
        pic  = int'(pic_line);
        act  = int'(act_lines);
        hl   = 2 * m_line + ((m_tick >= LT / 2) ? 1 : 0);
        hpos = m_tick % (LT / 2);
        invs = (m_field != 0) ? (hl >= 1 && hl <= 5) : (hl <= 4);
        hs_e = (m_tick >= HS);
        cs_e = invs ? (hpos < HS) : hs_e;
        pix_e = (m_tick >= PS) && (m_tick < PS + PT) && (m_line >= pic) && (m_line < pic + act);
        pic_e = (m_tick == 0) && (m_line == pic);
        check("R2 tick", int'(tick_cnt), m_tick);
        check("R3 line", int'(line_cnt), m_line);
        check("R3 field", int'(field_odd), m_field);
        check("R4 hs_n", int'(hs_n), int'(hs_e));
        check(invs ? "R5 csync_n" : "R6 csync_n", int'(csync_n), int'(cs_e));
        check((act == 0) ? "R10 pix_en" : "R7 pix_en", int'(pix_en), int'(pix_e));
        check("R8 pic_start", int'(pic_start), int'(pic_e));
    endtask

    // One clock with given inputs; model follows the requirements.
    task automatic step(input bit te, input bit es);
        tick_en  = te;
        ext_sync = es;
        @(posedge clk);
        if (es) begin
            m_tick = 0; m_line = 0; m_field = 0;
        end else if (te) begin
            if (m_tick == LT - 1) begin
                m_tick = 0;
                if (m_line == ((m_field != 0) ? FL : FL - 1)) begin
                    m_line = 0;
                    m_field = 1 - m_field;
                end else begin
                    m_line++;
                end
            end else begin
                m_tick++;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_tick = 0; m_line = 0; m_field = 0;
        check("R1 tick", int'(tick_cnt), 0);
        check("R1 line", int'(line_cnt), 0);
        check("R1 field", int'(field_odd), 0);
        check("R1 hs_n", int'(hs_n), 0);
        rst_n = 1'b1;
        tick_en = 1'b0;
    endtask

    initial begin
        int pcount, mcount;
        @(negedge clk);
        do_reset();

        // Table walk: one full frame per picture window.
        for (int v = 0; v < NVEC; v++) begin
            pic_line  = LW'(VEC_PIC[v]);
            act_lines = LW'(VEC_ACT[v]);
            step(1'b1, 1'b1);
            pcount = 0;
            mcount = 0;
            for (int n = 0; n < FRAME_TICKS; n++) begin
                step(1'b1, 1'b0);
                if (pix_en) pcount++;
                if (pic_start) mcount++;
                if (n % 7 == 3) step(1'b0, 1'b0);
            end
            check((VEC_ACT[v] == 0) ? "R10 pixel count" : "R7 pixel count", pcount, VEC_PIX[v]);
            check("R8 markers per frame", mcount, 2);
            check("R3 frame wrap line", int'(line_cnt), 0);
        end

        // R3: odd field has the extra line.
        pic_line = LW'(4);
        act_lines = LW'(2);
        step(1'b1, 1'b1);
        for (int n = 0; n < FL * LT; n++) step(1'b1, 1'b0);
        check("R3 odd phase entered", int'(field_odd), 1);
        for (int n = 0; n < FL * LT; n++) step(1'b1, 1'b0);
        check("R3 extra line", int'(line_cnt), FL);
        check("R3 still odd", int'(field_odd), 1);
        for (int n = 0; n < LT; n++) step(1'b1, 1'b0);
        check("R3 back to even", int'(field_odd), 0);

        // R9: genlock with ticks stalled, mid-frame in the odd field.
        for (int n = 0; n < FL * LT + 5 * LT + 7; n++) step(1'b1, 1'b0);
        for (int n = 0; n < 3; n++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check("R9 tick", int'(tick_cnt), 0);
        check("R9 line", int'(line_cnt), 0);
        check("R9 field", int'(field_odd), 0);
        step(1'b1, 1'b0);
        check("R9 resumes", int'(tick_cnt), 1);

        // R1: reset in mid-frame.
        for (int n = 0; n < 3 * LT + 9; n++) step(1'b1, 1'b0);
        @(negedge clk);
        do_reset();
        step(1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog R1..: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule